// File: doc/BRIEF.md
# Eight-Region Address Protection and Translation Unit

This block checks and translates every memory access of a 32-bit core against a fixed set of eight equal regions. The top three address bits pick the region. Each region has one entry in an instruction table and one in a data table. An entry holds a physical base and a 4-bit attribute code.

A lookup is purely combinational. It takes a virtual address and an access kind and returns four things: a physical address, a page size, a grant flag and a fault cause. The instruction table serves fetches; loads and stores use the data table. Entries are rewritten through a single registered write port, and a select input picks which table the write goes to.

When protection is switched off, the unit passes addresses through unchanged and grants every access.

Top module: `region_guard`

## Requirements
- R1: The region index is vaddr[31:29]. A fetch (kind 2) is looked up in the instruction table. Loads (kind 0), stores (kind 1) and reserved accesses (kind 3) are looked up in the data table.
- R2: With protection on, a load or a store is granted when the entry attribute is 14, or when it is below 6 and not 3. A reserved access (kind 3) is never granted.
- R3: With protection on, a fetch is granted only when the instruction entry attribute is between 1 and 5 inclusive.
- R4: With protection on, lk_paddr equals the entry base bitwise-ORed with vaddr[28:0], and lk_page is 0x2000_0000.
- R5: lk_cause is 0 when the access is granted. A denied fetch gives 1, a denied store gives 3, and a denied load or reserved access gives 2.
- R6: After reset, entry i of both tables has base i<<29 and attribute 2.
- R7: With prot_en low, lk_paddr equals lk_vaddr, lk_ok is 1, lk_cause is 0 and lk_page is 4096, whatever the table contents hold.
- R8: A write with wr_en high updates the entry at the next rising clock edge. A lookup in the same cycle as the write still sees the old entry.
- R9: wr_itab high writes the instruction table and low writes the data table. The table that is not selected is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | 1: region protection active; 0: identity bypass |
| lk_vaddr | input | 32 | Virtual address to look up |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| lk_paddr | output | 32 | Translated physical address |
| lk_page | output | 32 | Page size in bytes |
| lk_ok | output | 1 | Access granted |
| lk_cause | output | 2 | 0 none, 1 fetch, 2 load, 3 store prohibited |
| wr_en | input | 1 | Entry write strobe |
| wr_itab | input | 1 | 1: instruction table, 0: data table |
| wr_idx | input | 3 | Region entry to write |
| wr_base | input | 32 | New physical base |
| wr_attr | input | 4 | New attribute code |

## Verification
The bench sweeps all sixteen attribute codes against all four access kinds in every region. A decode that grants execute on the read/write-only code 14, or that grants read/write on code 3, therefore shows up as a wrong grant or a wrong cause.

Each sweep writes bases whose high bits differ from the region number and whose low bits are non-zero. A design that replaced the base bits instead of ORing them, or that indexed the table by the wrong address bits, would return a wrong physical address.

The bench also probes several cycles:
- It looks up an entry in the same cycle as its write, which exposes a write path that behaves as if it were combinational.
- It writes only one table and then reads the other, which catches a select input that writes both tables.
- It fills the tables with no-access codes and then turns protection off, which exposes a bypass that still applies the table.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int AW          = 32,
  parameter int IDX_W       = 3,
  parameter int ATTR_W      = 4,
  parameter int RESET_ATTR  = 2,
  parameter int BYPASS_PAGE = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic [AW-1:0]     lk_vaddr,
  input  logic [1:0]        lk_kind,
  output logic [AW-1:0]     lk_paddr,
  output logic [AW-1:0]     lk_page,
  output logic              lk_ok,
  output logic [1:0]        lk_cause,
  input  logic              wr_en,
  input  logic              wr_itab,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [AW-1:0]     wr_base,
  input  logic [ATTR_W-1:0] wr_attr
);
  localparam int NREG  = 1 << IDX_W;
  localparam int OFF_W = AW - IDX_W;

  logic [AW-1:0]     ibase [NREG];
  logic [AW-1:0]     dbase [NREG];
  logic [ATTR_W-1:0] iattr [NREG];
  logic [ATTR_W-1:0] dattr [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        ibase[i] <= AW'(i) << OFF_W;
        dbase[i] <= AW'(i) << OFF_W;
        iattr[i] <= ATTR_W'(RESET_ATTR);
        dattr[i] <= ATTR_W'(RESET_ATTR);
      end
    end else if (wr_en) begin
      if (wr_itab) begin
        ibase[wr_idx] <= wr_base;
        iattr[wr_idx] <= wr_attr;
      end else begin
        dbase[wr_idx] <= wr_base;
        dattr[wr_idx] <= wr_attr;
      end
    end
  end

  wire [IDX_W-1:0]  idx      = lk_vaddr[AW-1:OFF_W];
  wire              is_fetch = (lk_kind == 2'd2);
  wire [AW-1:0]     sel_base = is_fetch ? ibase[idx] : dbase[idx];
  wire [ATTR_W-1:0] sel_attr = is_fetch ? iattr[idx] : dattr[idx];

  wire rw_ok = (sel_attr < ATTR_W'(6) && sel_attr != ATTR_W'(3)) || sel_attr == ATTR_W'(14);
  wire x_ok  = sel_attr >= ATTR_W'(1) && sel_attr <= ATTR_W'(5);

  logic granted;
  always_comb begin
    case (lk_kind)
      2'd0, 2'd1: granted = rw_ok;
      2'd2:       granted = x_ok;
      default:    granted = 1'b0;
    endcase
  end

  assign lk_ok    = !prot_en || granted;
  assign lk_cause = lk_ok ? 2'd0 :
                    is_fetch ? 2'd1 :
                    (lk_kind == 2'd1) ? 2'd3 : 2'd2;
  assign lk_paddr = prot_en ? (sel_base | {{IDX_W{1'b0}}, lk_vaddr[OFF_W-1:0]}) : lk_vaddr;
  assign lk_page  = prot_en ? (AW'(1) << OFF_W) : AW'(BYPASS_PAGE);

  a_r5_grant_has_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ok |-> lk_cause == 2'd0);
  a_r5_denied_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_ok && lk_kind == 2'd1) |-> lk_cause == 2'd3);
  a_r7_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (lk_ok && lk_paddr == lk_vaddr));
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en |-> lk_paddr[OFF_W-1:0] >= lk_vaddr[OFF_W-1:0] && (lk_paddr[OFF_W-1:0] & lk_vaddr[OFF_W-1:0]) == lk_vaddr[OFF_W-1:0]);
  a_r8_write_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && prot_en && idx == $past(wr_idx) && is_fetch == $past(wr_itab) && lk_kind != 2'd3)
      |-> lk_paddr == ($past(wr_base) | {{IDX_W{1'b0}}, lk_vaddr[OFF_W-1:0]}));
endmodule

// File: tb/region_guard_bench.sv
module region_guard_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        prot_en = 1;
  logic [31:0] lk_vaddr = 0;
  logic [1:0]  lk_kind = 0;
  logic [31:0] lk_paddr, lk_page;
  logic        lk_ok;
  logic [1:0]  lk_cause;
  logic        wr_en = 0, wr_itab = 0;
  logic [2:0]  wr_idx = 0;
  logic [31:0] wr_base = 0;
  logic [3:0]  wr_attr = 0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  region_guard u_region_guard (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_paddr(lk_paddr), .lk_page(lk_page), .lk_ok(lk_ok), .lk_cause(lk_cause),
    .wr_en(wr_en), .wr_itab(wr_itab), .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr)
  );

  function automatic bit exp_grant(input int attr, input int kind);
    if (kind == 2) return attr >= 1 && attr <= 5;
    if (kind == 3) return 0;
    return (attr < 6 && attr != 3) || attr == 14;
  endfunction

  function automatic int exp_cause(input bit ok, input int kind);
    if (ok) return 0;
    if (kind == 2) return 1;
    if (kind == 1) return 3;
    return 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (vaddr %h kind %0d)", req, act, exp, lk_vaddr, lk_kind);
    end
  endtask

  task automatic write(input bit itab, input int idx, input logic [31:0] base, input int attr);
    @(negedge clk);
    wr_en = 1; wr_itab = itab; wr_idx = 3'(idx); wr_base = base; wr_attr = 4'(attr);
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input int kind);
    lk_vaddr = va; lk_kind = 2'(kind);
    #1;
  endtask

  task automatic check_full(input int attr, input logic [31:0] base, input logic [31:0] va, input int kind);
    bit ok;
    look(va, kind);
    ok = exp_grant(attr, kind);
    check(kind == 2 ? "R3" : "R2", 32'(lk_ok), 32'(ok));
    check("R5", 32'(lk_cause), 32'(exp_cause(ok, kind)));
    check("R4", lk_paddr, base | (va & 32'h1FFF_FFFF));
    check("R4", lk_page, 32'h2000_0000);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);

    // R6 reset state, R1 index by top bits
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++)
        check_full(2, 32'(r) << 29, (32'(r) << 29) | 32'h0123_4567, k);

    // R2 R3 R4 R5 R1: full attribute sweep in every region
    for (int r = 0; r < 8; r++)
      for (int a = 0; a < 16; a++) begin
        logic [31:0] base;
        base = (32'(7 - r) << 29) | (32'(a) << 4);
        write(1, r, base, a);
        write(0, r, base, a);
        @(negedge clk);
        for (int k = 0; k < 4; k++)
          check_full(a, base, (32'(r) << 29) | 32'h0ABC_DE01 | 32'(r * 64), k);
      end

    // R7: bypass with every entry set to no-access
    for (int r = 0; r < 8; r++) begin
      write(1, r, 32'h0, 15);
      write(0, r, 32'h0, 15);
    end
    @(negedge clk);
    prot_en = 0;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++) begin
        look((32'(r) << 29) | 32'h0F0F_0F0F, k);
        check("R7", 32'(lk_ok), 1);
        check("R7", 32'(lk_cause), 0);
        check("R7", lk_paddr, (32'(r) << 29) | 32'h0F0F_0F0F);
        check("R7", lk_page, 32'd4096);
      end
    prot_en = 1;
    look(32'h4000_0000, 0);
    check("R7", 32'(lk_ok), 0);

    // R8: same-cycle lookup sees old entry, next cycle sees new
    @(negedge clk);
    wr_en = 1; wr_itab = 0; wr_idx = 3'd3; wr_base = 32'hE000_0000; wr_attr = 4'd14;
    look(32'h6000_0010, 0);
    check("R8", 32'(lk_ok), 0);
    check("R8", lk_paddr, 32'h0000_0010);
    @(posedge clk);
    #1 wr_en = 0;
    @(negedge clk);
    look(32'h6000_0010, 1);
    check("R8", 32'(lk_ok), 1);
    check("R8", lk_paddr, 32'hE000_0010);

    // R9: instruction write leaves data table alone and vice versa
    write(1, 5, 32'h2000_0000, 4);
    @(negedge clk);
    look(32'hA000_0100, 2);
    check("R9", 32'(lk_ok), 1);
    check("R9", lk_paddr, 32'h2000_0100);
    look(32'hA000_0100, 0);
    check("R9", 32'(lk_ok), 0);
    check("R9", lk_paddr, 32'h0000_0100);
    write(0, 6, 32'h4000_0000, 14);
    @(negedge clk);
    look(32'hC000_0200, 2);
    check("R9", 32'(lk_ok), 0);
    check("R9", 32'(lk_cause), 1);
    check("R9", lk_paddr, 32'h0000_0200);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule